// File: doc/BRIEF.md
# Rate-select sample clock generator

This block turns a free-running master clock into the sample strobe that paces a majority-vote noise filter on a slow binary data stream. A two-bit select code picks the data rate. At 16 samples per bit, the three bit rates are the master clock divided by 64, 32 or 16, so the strobe is the master clock divided by 4, 2 or 1. The same code also decides whether the filter runs at double bandwidth. At the top rate, double bandwidth does not speed up the strobe. Instead, a flag is raised that tells the filter to vote over half its usual window.

The strobe is an enable pulse one master clock wide. It comes from a prescaler counter that restarts whenever the select code changes. A chip-enable input gates the whole block. While it is low, no strobe is issued, so all filter state downstream holds still, and the output-enable for the tri-stated data pin is withdrawn. When chip-enable returns, the first strobe comes only after one full divide period.

Top module: `smpclk_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `smp_stb` is 0. Reset leaves the stored select code at 00 and the prescaler at zero.
- R2: Code `rate_sel` = 00 (bit rate = clock/64) gives a strobe on every 4th enabled cycle, with `half_win` = 0.
- R3: Code 01 (bit rate = clock/32) gives a strobe on every 2nd enabled cycle, with `half_win` = 0.
- R4: Code 10 (bit rate = clock/16) gives a strobe on every enabled cycle, with `half_win` = 0.
- R5: Code 11 (clock/16, double bandwidth) gives a strobe on every enabled cycle, with `half_win` = 1. `half_win` follows the code whether or not the block is enabled.
- R6: While `chip_en` = 0, `smp_stb` = 0 and `drv_en` = 0. While `chip_en` = 1, `drv_en` = 1.
- R7: After `chip_en` rises, the first strobe falls on the N-th consecutive enabled cycle, where N is the divide ratio of the current code (4, 2 or 1).
- R8: A cycle in which `rate_sel` differs from its value in the previous cycle carries no strobe. The prescaler restarts, so the next strobe falls on the N-th enabled cycle after that one.
- R9: Every strobe is exactly one cycle wide when N > 1. Between two strobes of the same code, at least N-1 cycles pass with no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Block enable; low freezes the strobe |
| rate_sel | input | 2 | Rate and bandwidth select code |
| smp_stb | output | 1 | One-cycle sample-enable pulse |
| half_win | output | 1 | Tells the filter to vote over half its window |
| drv_en | output | 1 | Output-enable for the tri-stated data pin |

## Verification
A prescaler that is out of step shows up as a strobe in the wrong cycle within at most four enabled cycles, because the bench predicts the exact strobe cycle from the count of enabled, unchanged-code cycles. A missed restart after a code change, or a short first period after enable, changes the phase of the very next strobe. A wrong decode of the code shows up at once in `half_win`, and within one divide period in the strobe spacing.

// File: rtl/smpclk_pkg.sv
package smpclk_pkg;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned MAX_DIV = 4;
  localparam int unsigned CNT_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_SLOW  = 2'b00,
    SEL_MID   = 2'b01,
    SEL_FAST  = 2'b10,
    SEL_FAST_HW = 2'b11
  } rate_code_e;

  // Master clocks per sample strobe for each select code.
  function automatic int unsigned strobe_div(input logic [SEL_W-1:0] code);
    case (code)
      SEL_SLOW: strobe_div = MAX_DIV;
      SEL_MID:  strobe_div = MAX_DIV / 2;
      default:  strobe_div = 1;
    endcase
  endfunction

  function automatic logic halves_window(input logic [SEL_W-1:0] code);
    halves_window = (code == SEL_FAST_HW);
  endfunction
endpackage

// File: rtl/smpclk_decode.sv
module smpclk_decode
  import smpclk_pkg::*;
(
  input  logic [SEL_W-1:0] code,
  output logic [CNT_W-1:0] term,
  output logic             half_win
);
  always_comb begin
    term     = CNT_W'(strobe_div(code) - 1);
    half_win = halves_window(code);
  end
endmodule

// File: rtl/smpclk_prescale.sv
module smpclk_prescale
  import smpclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] term,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  assign tick = run && !restart && (cnt == term);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart || tick) cnt <= '0;
    else                                   cnt <= cnt + 1'b1;
  end

  // R9: the count never passes the terminal value of a steady code
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart) |-> (cnt <= term));
  // R7: a disabled cycle leaves the count at zero for the next run
  a_r7_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/smpclk_gen.sv
module smpclk_gen
  import smpclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic [SEL_W-1:0] rate_sel,
  output logic             smp_stb,
  output logic             half_win,
  output logic             drv_en
);
  logic [SEL_W-1:0] sel_q;
  logic             code_chg;
  logic [CNT_W-1:0] term;
  logic             tick;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= SEL_SLOW;
    else        sel_q <= rate_sel;
  end

  assign code_chg = (rate_sel != sel_q);

  smpclk_decode u_dec (
    .code     (rate_sel),
    .term     (term),
    .half_win (half_win)
  );

  smpclk_prescale u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (chip_en),
    .restart (code_chg),
    .term    (term),
    .tick    (tick)
  );

  assign smp_stb = tick;
  assign drv_en  = chip_en;

  // R6: no strobe leaves the block while the pin driver is released
  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> !smp_stb);
  // R8: a code change cycle never carries a strobe
  a_r8_no_stb_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    code_chg |-> !smp_stb);
  // R9: at the slowest code a strobe is followed by a gap
  a_r9_gap_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && rate_sel == SEL_SLOW) |=> !smp_stb);
  // R5: the window flag and a non-unity divide are exclusive
  a_r5_flag_fast_only: assert property (@(posedge clk) disable iff (!rst_n)
    half_win |-> (term == '0));
  // R4: steady fast code while enabled strobes each cycle
  a_r4_fast_every: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && !code_chg && rate_sel[1]) |-> smp_stb);
endmodule

// File: tb/smpclk_gen_test.sv
module smpclk_gen_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_en = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       smp_stb, half_win, drv_en;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [1:0] prev_sel = 2'b00;
  int run_len = 0;

  smpclk_gen uut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .rate_sel(rate_sel),
    .smp_stb(smp_stb), .half_win(half_win), .drv_en(drv_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ratio_for(input logic [1:0] s);
    if (s[1]) return 1;
    return s[0] ? 2 : 4;
  endfunction

  function automatic string tag_for(input logic [1:0] s);
    case (s)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", req, cyc, act, exp);
    end
  endtask

  // Apply inputs after a falling edge, check just before the rising edge,
  // then advance the bench's model of the strobe phase.
  task automatic step(input logic en, input logic [1:0] sel, input string req);
    logic exp_stb;
    @(negedge clk);
    chip_en  = en;
    rate_sel = sel;
    if (!en || sel != prev_sel) run_len = 0;
    else                        run_len++;
    exp_stb = en && (sel == prev_sel) && (run_len % ratio_for(sel) == 0);
    #(CLK_PERIOD/4);
    check(req, smp_stb, exp_stb);
    check("R6", drv_en, en);
    check("R5", half_win, sel == 2'b11);
    prev_sel = sel;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  always @(posedge clk) cyc++;

  initial begin : stim
    void'($urandom(32'h5A17));
    // R1: reset holds the strobe low even with enable and a fast code
    @(negedge clk);
    chip_en = 1'b1; rate_sel = 2'b10;
    #(CLK_PERIOD/4);
    check("R1", smp_stb, 1'b0);
    repeat (2) @(negedge clk);
    chip_en = 1'b0; rate_sel = 2'b00;
    @(negedge clk);
    rst_n = 1'b1;
    prev_sel = 2'b00; run_len = 0;
    // R1: first cycle out of reset with code 00 enabled: no strobe yet
    step(1'b1, 2'b00, "R1");
    // R2 / R7: the strobe then falls on the 4th enabled cycle
    for (int i = 0; i < 11; i++) step(1'b1, 2'b00, "R2");
    // R6: disable, then R7: re-enable with a full period before the strobe
    for (int i = 0; i < 3; i++) step(1'b0, 2'b00, "R6");
    for (int i = 0; i < 8; i++) step(1'b1, 2'b00, "R7");
    // R3 with R8: a code change cycle carries no strobe
    for (int i = 0; i < 8; i++) step(1'b1, 2'b01, "R8");
    // R4
    for (int i = 0; i < 6; i++) step(1'b1, 2'b10, "R4");
    // R5 flag holds even while disabled
    for (int i = 0; i < 3; i++) step(1'b0, 2'b11, "R5");
    for (int i = 0; i < 6; i++) step(1'b1, 2'b11, "R5");
    // R8: changing the code on the cycle before a slow strobe restarts the count
    for (int i = 0; i < 3; i++) step(1'b1, 2'b00, "R8");
    for (int i = 0; i < 6; i++) step(1'b1, 2'b01, "R8");
    // random mix: R9 spacing and every code's rate
    for (int i = 0; i < 3000; i++) begin
      logic       en;
      logic [1:0] sel;
      en  = ($urandom % 10) != 0;
      sel = (($urandom % 8) == 0) ? 2'($urandom) : prev_sel;
      step(en, sel, (sel == prev_sel) ? tag_for(sel) : "R9");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule